// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI/LO Interlock

This block is the integer multiply and divide engine of a 64-bit in-order pipeline. The pipeline issues a request with a one-cycle start strobe, an opcode, two operands and a width select. The unit takes several cycles to finish, then writes its two results into a pair of dedicated result registers, HI and LO. Software later copies these into general registers with move-from-HI and move-from-LO operations.

The time an operation takes depends on what it is. Divides run for a fixed count that depends on the width. Multiplies end early when the second operand is small. While an operation is in flight, the unit asserts a stall request toward the pipeline in three cases: when the pipeline tries to read HI or LO, and when it tries to start a new operation. A start issued during a stall is dropped. A divide by zero does not trap. It finishes in the normal time and leaves fixed, documented values in HI and LO.

Top module: `hilo_muldiv`

## Requirements
- R1: While reset is held and on the first cycle after it, hi_o and lo_o read zero and busy_o and stall_o are low.
- R2: Opcode op_i[1]=0 selects multiply and op_i[0]=1 selects signed operands. With wide_i=1 the full 128-bit product of the 64-bit operands is formed: LO receives bits 63:0 and HI receives bits 127:64.
- R3: With wide_i=0 only bits 31:0 of each operand are used. Each 32-bit result is sign-extended from its bit 31 into the 64-bit register. The product's bits 31:0 go to LO and its bits 63:32 go to HI.
- R4: Opcode op_i[1]=1 selects divide. LO receives the quotient, truncated toward zero. HI receives the remainder, which carries the sign of the dividend. The 32-bit case -2^31 / -1 leaves LO = 0xFFFFFFFF80000000 and HI = 0.
- R5: A divide keeps busy_o high for exactly 42 cycles at 32-bit width and 74 cycles at 64-bit width. HI and LO take the result on the clock edge that drops busy_o.
- R6: A multiply keeps busy_o high for a base count plus k cycles. The base is 6 at 32-bit width and 7 at 64-bit width. k is 0 if the second operand fits in 8 bits, 1 if it fits in 16 bits, and 2 if it fits in 24 bits (32-bit width) or 32 bits (64-bit width); otherwise k is 3. For a signed operand, fitting in n bits means its value lies in [-2^(n-1), 2^(n-1)). For an unsigned operand it means its value is below 2^n.
- R7: A zero divisor raises no trap and uses the normal divide latency. LO becomes all ones. HI becomes the dividend, which at 32-bit width is sign-extended from bit 31.
- R8: While busy_o is high, hi_o and lo_o keep the values they held before the operation started.
- R9: While busy_o is high, a read request on rd_hi_i or rd_lo_i asserts stall_o in the same cycle.
- R10: While busy_o is high, start_i asserts stall_o and the new request is discarded. It has no effect on the running operation or on its result.
- R11: While busy_o is low, stall_o stays low. A start is accepted on any edge where busy_o is low, so an operation can follow the previous one after a single idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request strobe for a new operation |
| op_i | input | 2 | Bit 1: divide (1) or multiply (0); bit 0: signed (1) or unsigned (0) |
| wide_i | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| a_i | input | 64 | First operand (multiplicand or dividend) |
| b_i | input | 64 | Second operand (multiplier or divisor) |
| rd_hi_i | input | 1 | Pipeline wants to read HI this cycle |
| rd_lo_i | input | 1 | Pipeline wants to read LO this cycle |
| hi_o | output | 64 | HI result register |
| lo_o | output | 64 | LO result register |
| busy_o | output | 1 | An operation is in flight |
| stall_o | output | 1 | Pipeline must hold the current read or start request |

## Verification
The bench builds the unit with its default parameters: 64-bit words, multiply bases of 6 and 7, and divide counts of 42 and 74. Under these parameters each multiply early-exit step is a distinct, measurable latency, and the full-width divider runs its whole 64-step iteration with padding cycles left before completion. The defaults also bring within reach the most negative 32-bit value divided by minus one, zero divisors at both widths, and reads and starts poked into every cycle of a long divide.

// File: rtl/mdu_pkg.sv
// Package: shared opcode encoding for the multiply/divide unit.
// Assumes bit 1 of the opcode selects divide and bit 0 selects signed.
package mdu_pkg;

    typedef enum logic [1:0] {
        MD_MULU = 2'b00,
        MD_MULS = 2'b01,
        MD_DIVU = 2'b10,
        MD_DIVS = 2'b11
    } md_op_e;

    // True for the two divide encodings.
    function automatic logic op_is_div(input logic [1:0] op);
        return (op == MD_DIVU) || (op == MD_DIVS);
    endfunction

    // True for the two signed encodings.
    function automatic logic op_is_signed(input logic [1:0] op);
        return (op == MD_MULS) || (op == MD_DIVS);
    endfunction

endpackage

// File: rtl/mdu_latency.sv
// Module: mdu_latency
// Works out how many cycles a request will occupy the unit.
// Divides take a fixed count per width. Multiplies take a base count plus one
// step for each size band the second operand exceeds.
// Assumes XLEN is a multiple of 8 and every resulting latency is at least 1.
module mdu_latency #(
    parameter int XLEN            = 64,
    parameter int MUL_NARROW_BASE = 6,
    parameter int MUL_WIDE_BASE   = 7,
    parameter int DIV_NARROW_LAT  = 42,
    parameter int DIV_WIDE_LAT    = 74,
    parameter int CW              = 7
) (
    input  logic            is_div,
    input  logic            is_signed,
    input  logic            wide,
    input  logic [XLEN-1:0] b,
    output logic [CW-1:0]   lat
);
    localparam int HALF    = XLEN / 2;
    localparam int BAND_1  = XLEN / 8;
    localparam int BAND_2  = XLEN / 4;
    localparam int BAND_3N = (3 * XLEN) / 8;
    localparam int BAND_3W = XLEN / 2;

    // True when v, viewed as a w-bit value, needs no more than k bits.
    function automatic logic fits(input logic [XLEN-1:0] v, input int k,
                                  input int w, input logic sgn);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < XLEN; i++) begin
            if (i < w) begin
                if (sgn && (i >= k - 1) && (v[i] != v[w-1])) ok = 1'b0;
                if (!sgn && (i >= k) && v[i]) ok = 1'b0;
            end
        end
        return ok;
    endfunction

    int width;
    int band3;
    int base;
    int steps;

    // Select the band limits for this width and count the extra multiply steps.
    always_comb begin
        width = wide ? XLEN : HALF;
        band3 = wide ? BAND_3W : BAND_3N;
        base  = wide ? MUL_WIDE_BASE : MUL_NARROW_BASE;
        if (fits(b, BAND_1, width, is_signed))      steps = 0;
        else if (fits(b, BAND_2, width, is_signed)) steps = 1;
        else if (fits(b, band3, width, is_signed))  steps = 2;
        else                                        steps = 3;
        if (is_div) lat = wide ? CW'(DIV_WIDE_LAT) : CW'(DIV_NARROW_LAT);
        else        lat = CW'(base + steps);
    end

endmodule

// File: rtl/mdu_multiplier.sv
// Module: mdu_multiplier
// Combinational product of the held operands.
// A 32-bit request extends its operands to the full word first, so the low
// word of the product holds the whole 64-bit result.
// Assumes the operands stay stable for the whole multiply latency.
module mdu_multiplier #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    input  logic              is_signed,
    input  logic              wide,
    output logic [2*XLEN-1:0] prod
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0]   xa, xb;
    logic [2*XLEN-1:0] ea, eb;

    // Form the operand views for the selected width and signedness.
    always_comb begin
        if (wide) begin
            xa = a;
            xb = b;
        end else begin
            xa = {{HALF{is_signed & a[HALF-1]}}, a[HALF-1:0]};
            xb = {{HALF{is_signed & b[HALF-1]}}, b[HALF-1:0]};
        end
        ea   = {{XLEN{is_signed & xa[XLEN-1]}}, xa};
        eb   = {{XLEN{is_signed & xb[XLEN-1]}}, xb};
        prod = ea * eb;
    end

endmodule

// File: rtl/mdu_divider.sv
// Module: mdu_divider
// Restoring divider that produces one quotient bit per cycle on magnitudes and
// fixes the signs at the output. It runs HALF or XLEN steps after a load.
// A zero divisor gives an all-ones quotient and returns the dividend as the
// remainder.
// Assumes the caller keeps the operation open for at least the step count.
module mdu_divider #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            is_signed,
    input  logic            wide,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] quot,
    output logic [XLEN-1:0] rem_out
);
    localparam int HALF = XLEN / 2;
    localparam int IW   = $clog2(XLEN + 1);

    logic [XLEN-1:0] xa, xb, mag_a, mag_b;
    logic [XLEN-1:0] rem_q, quo_q, dvs_q, dnd_q;
    logic [IW-1:0]   iter_q;
    logic            neg_q_q, neg_r_q, dz_q;
    logic [XLEN:0]   rem_sh, diff;

    // Extend the raw operands to the word and take their magnitudes.
    always_comb begin
        if (wide) begin
            xa = a;
            xb = b;
        end else begin
            xa = {{HALF{is_signed & a[HALF-1]}}, a[HALF-1:0]};
            xb = {{HALF{is_signed & b[HALF-1]}}, b[HALF-1:0]};
        end
        mag_a = (is_signed && xa[XLEN-1]) ? -xa : xa;
        mag_b = (is_signed && xb[XLEN-1]) ? -xb : xb;
    end

    // One restoring step: shift in the next dividend bit and try the divisor.
    always_comb begin
        rem_sh = {rem_q, quo_q[XLEN-1]};
        diff   = rem_sh - {1'b0, dvs_q};
    end

    // Load the operands, then iterate until the step counter reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            quo_q   <= '0;
            dvs_q   <= '0;
            dnd_q   <= '0;
            iter_q  <= '0;
            neg_q_q <= 1'b0;
            neg_r_q <= 1'b0;
            dz_q    <= 1'b0;
        end else if (load) begin
            rem_q   <= '0;
            quo_q   <= wide ? mag_a : {mag_a[HALF-1:0], {HALF{1'b0}}};
            dvs_q   <= mag_b;
            dnd_q   <= xa;
            iter_q  <= wide ? IW'(XLEN) : IW'(HALF);
            neg_q_q <= is_signed & (xa[XLEN-1] ^ xb[XLEN-1]);
            neg_r_q <= is_signed & xa[XLEN-1];
            dz_q    <= (xb == '0);
        end else if (iter_q != '0) begin
            iter_q <= iter_q - 1'b1;
            if (!diff[XLEN]) begin
                rem_q <= diff[XLEN-1:0];
                quo_q <= {quo_q[XLEN-2:0], 1'b1};
            end else begin
                rem_q <= rem_sh[XLEN-1:0];
                quo_q <= {quo_q[XLEN-2:0], 1'b0};
            end
        end
    end

    // Apply the result signs, or the fixed values for a zero divisor.
    always_comb begin
        if (dz_q) begin
            quot    = '1;
            rem_out = dnd_q;
        end else begin
            quot    = neg_q_q ? -quo_q : quo_q;
            rem_out = neg_r_q ? -rem_q : rem_q;
        end
    end

endmodule

// File: rtl/hilo_muldiv.sv
// Module: hilo_muldiv (top)
// Accepts multiply and divide requests, runs each for its computed latency
// and then writes HI and LO. Reads and starts made while busy are stalled.
// Assumes the pipeline repeats a stalled read itself. A stalled start is
// dropped and the pipeline must reissue it.
module hilo_muldiv
    import mdu_pkg::*;
#(
    parameter int XLEN            = 64,
    parameter int MUL_NARROW_BASE = 6,
    parameter int MUL_WIDE_BASE   = 7,
    parameter int DIV_NARROW_LAT  = 42,
    parameter int DIV_WIDE_LAT    = 74
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic            wide_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            rd_hi_i,
    input  logic            rd_lo_i,
    output logic [XLEN-1:0] hi_o,
    output logic [XLEN-1:0] lo_o,
    output logic            busy_o,
    output logic            stall_o
);
    localparam int HALF = XLEN / 2;
    localparam int CW   = $clog2(DIV_WIDE_LAT + 1);

    logic              busy_q;
    logic [CW-1:0]     cnt_q;
    logic              div_q, sgn_q, wide_q;
    logic [XLEN-1:0]   opa_q, opb_q;
    logic [XLEN-1:0]   hi_q, lo_q;
    logic [CW-1:0]     lat;
    logic              accept, finish;
    logic              req_div, req_sgn;
    logic [2*XLEN-1:0] prod;
    logic [XLEN-1:0]   quot, rem_val;
    logic [XLEN-1:0]   res_hi, res_lo;

    assign req_div = op_is_div(op_i);
    assign req_sgn = op_is_signed(op_i);
    assign accept  = start_i && !busy_q;
    assign finish  = busy_q && (cnt_q == '0);

    mdu_latency #(
        .XLEN(XLEN), .MUL_NARROW_BASE(MUL_NARROW_BASE),
        .MUL_WIDE_BASE(MUL_WIDE_BASE), .DIV_NARROW_LAT(DIV_NARROW_LAT),
        .DIV_WIDE_LAT(DIV_WIDE_LAT), .CW(CW)
    ) lat_i (
        .is_div(req_div), .is_signed(req_sgn), .wide(wide_i), .b(b_i), .lat(lat)
    );

    mdu_multiplier #(.XLEN(XLEN)) mul_i (
        .a(opa_q), .b(opb_q), .is_signed(sgn_q), .wide(wide_q), .prod(prod)
    );

    mdu_divider #(.XLEN(XLEN)) div_i (
        .clk(clk), .rst_n(rst_n), .load(accept && req_div),
        .is_signed(req_sgn), .wide(wide_i), .a(a_i), .b(b_i),
        .quot(quot), .rem_out(rem_val)
    );

    // Select the finished result and sign-extend it for 32-bit requests.
    always_comb begin
        if (div_q) begin
            res_lo = wide_q ? quot : {{HALF{quot[HALF-1]}}, quot[HALF-1:0]};
            res_hi = wide_q ? rem_val : {{HALF{rem_val[HALF-1]}}, rem_val[HALF-1:0]};
        end else if (wide_q) begin
            res_lo = prod[XLEN-1:0];
            res_hi = prod[2*XLEN-1:XLEN];
        end else begin
            res_lo = {{HALF{prod[HALF-1]}}, prod[HALF-1:0]};
            res_hi = {{HALF{prod[XLEN-1]}}, prod[XLEN-1:HALF]};
        end
    end

    // Sequence the operation: accept, count down, then commit HI and LO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            div_q  <= 1'b0;
            sgn_q  <= 1'b0;
            wide_q <= 1'b0;
            opa_q  <= '0;
            opb_q  <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= lat - 1'b1;
            div_q  <= req_div;
            sgn_q  <= req_sgn;
            wide_q <= wide_i;
            opa_q  <= a_i;
            opb_q  <= b_i;
        end else if (finish) begin
            busy_q <= 1'b0;
            hi_q   <= res_hi;
            lo_q   <= res_lo;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign hi_o    = hi_q;
    assign lo_o    = lo_q;
    assign busy_o  = busy_q;
    assign stall_o = busy_q && (start_i || rd_hi_i || rd_lo_i);

endmodule

// File: rtl/hilo_muldiv_chk.sv
// Module: hilo_muldiv_chk
// Checker for the port-level timing rules of hilo_muldiv. It is bound to the
// top module. Assumes reset is held low for at least one edge at time zero.
module hilo_muldiv_chk #(
    parameter int XLEN       = 64,
    parameter int BUSY_LIMIT = 74
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            rd_hi_i,
    input logic            rd_lo_i,
    input logic [XLEN-1:0] hi_o,
    input logic [XLEN-1:0] lo_o,
    input logic            busy_o,
    input logic            stall_o
);
    int run_len;

    // Count the busy cycles already seen in the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_len <= 0;
        else if (busy_o) run_len <= run_len + 1;
        else             run_len <= 0;
    end

    p_busy_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_len < BUSY_LIMIT));

    p_hold_results_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ($stable(hi_o) && $stable(lo_o)));

    p_read_stalls_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (rd_hi_i || rd_lo_i)) |-> stall_o);

    p_start_stalls_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |-> stall_o);

    p_idle_no_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !stall_o);

    p_start_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

endmodule

bind hilo_muldiv hilo_muldiv_chk #(
    .XLEN(XLEN), .BUSY_LIMIT(DIV_WIDE_LAT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_hi_i(rd_hi_i),
    .rd_lo_i(rd_lo_i), .hi_o(hi_o), .lo_o(lo_o), .busy_o(busy_o),
    .stall_o(stall_o)
);

// File: tb/hilo_muldiv_tb_top.sv
// Bench: a behavioural model of HI/LO, busy and stall is stepped on every edge
// and compared with the ports on every falling edge. Directed sequences
// measure latencies and poke reads and starts into running operations.
module hilo_muldiv_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic        wide_i = 1'b0;
    logic [63:0] a_i = '0, b_i = '0;
    logic        rd_hi_i = 1'b0, rd_lo_i = 1'b0;
    logic [63:0] hi_o, lo_o;
    logic        busy_o, stall_o;

    int total = 0;
    int bad = 0;
    bit checking = 1'b0;
    string res_tag = "R2";
    string lat_tag = "R6";

    // model state
    bit          m_busy = 1'b0;
    int          m_cnt = 0;
    logic [63:0] m_hi = '0, m_lo = '0, m_phi = '0, m_plo = '0;

    always #10 clk = ~clk;

    hilo_muldiv dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .wide_i(wide_i), .a_i(a_i), .b_i(b_i), .rd_hi_i(rd_hi_i),
        .rd_lo_i(rd_lo_i), .hi_o(hi_o), .lo_o(lo_o), .busy_o(busy_o),
        .stall_o(stall_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic int exp_lat(input logic [1:0] op, input logic w,
                                   input logic [63:0] b);
        longint sv;
        logic [63:0] uv;
        int base;
        int bands[3];
        if (op[1]) return w ? 74 : 42;
        base = w ? 7 : 6;
        bands[0] = 8; bands[1] = 16; bands[2] = w ? 32 : 24;
        sv = w ? longint'(b) : longint'(signed'(b[31:0]));
        uv = w ? b : {32'b0, b[31:0]};
        for (int i = 0; i < 3; i++) begin
            if (op[0]) begin
                if (sv >= -(64'sd1 <<< (bands[i] - 1)) && sv < (64'sd1 <<< (bands[i] - 1)))
                    return base + i;
            end else if (uv < (64'd1 << bands[i])) begin
                return base + i;
            end
        end
        return base + 3;
    endfunction

    task automatic exp_res(input logic [1:0] op, input logic w,
                           input logic [63:0] a, input logic [63:0] b,
                           output logic [63:0] hi, output logic [63:0] lo);
        longint x, y, q, r;
        logic [127:0] p;
        logic signed [127:0] sa, sb;
        logic [63:0] np;
        if (!w) begin
            x = op[0] ? longint'(signed'(a[31:0])) : longint'({32'b0, a[31:0]});
            y = op[0] ? longint'(signed'(b[31:0])) : longint'({32'b0, b[31:0]});
            if (!op[1]) begin
                np = x * y;
                lo = sx32(np[31:0]); hi = sx32(np[63:32]);
            end else begin
                if (y == 0) begin q = -1; r = x; end
                else begin q = x / y; r = x % y; end
                lo = sx32(q[31:0]); hi = sx32(r[31:0]);
            end
        end else if (!op[1]) begin
            if (op[0]) begin
                sa = signed'(a); sb = signed'(b); p = sa * sb;
            end else begin
                p = {64'b0, a} * {64'b0, b};
            end
            lo = p[63:0]; hi = p[127:64];
        end else if (b == 0) begin
            lo = '1; hi = a;
        end else if (op[0]) begin
            x = signed'(a); y = signed'(b);
            q = x / y; r = x % y;
            lo = q; hi = r;
        end else begin
            lo = a / b; hi = a % b;
        end
    endtask

    // Step the model on each rising edge.
    always @(posedge clk) begin
        logic [63:0] th, tl;
        if (!rst_n) begin
            m_busy <= 1'b0; m_cnt <= 0; m_hi <= '0; m_lo <= '0;
        end else if (m_busy) begin
            if (m_cnt == 1) begin
                m_busy <= 1'b0; m_hi <= m_phi; m_lo <= m_plo;
            end
            m_cnt <= m_cnt - 1;
        end else if (start_i) begin
            exp_res(op_i, wide_i, a_i, b_i, th, tl);
            m_phi <= th; m_plo <= tl;
            m_busy <= 1'b1;
            m_cnt <= exp_lat(op_i, wide_i, b_i);
        end
    end

    // Compare the ports with the model on each falling edge.
    always @(negedge clk) begin
        if (checking && rst_n) begin
            string stag;
            stag = !m_busy ? "R11" : (start_i ? "R10" : "R9");
            check(busy_o == m_busy, lat_tag, "busy", 64'(busy_o), 64'(m_busy));
            check(stall_o == (m_busy && (start_i || rd_hi_i || rd_lo_i)), stag,
                  "stall", 64'(stall_o), 64'(m_busy && (start_i || rd_hi_i || rd_lo_i)));
            check(hi_o == m_hi, m_busy ? "R8" : res_tag, "hi", hi_o, m_hi);
            check(lo_o == m_lo, m_busy ? "R8" : res_tag, "lo", lo_o, m_lo);
        end
    end

    // Issue one operation, optionally poking reads and starts while it runs.
    task automatic run_op(input logic [1:0] op, input logic w, input logic [63:0] a,
                          input logic [63:0] b, input string rtag, input string ltag,
                          input bit poke);
        int n;
        logic [63:0] eh, el;
        res_tag = rtag; lat_tag = ltag;
        @(negedge clk); #1;
        op_i = op; wide_i = w; a_i = a; b_i = b; start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        n = 0;
        while (busy_o && n < 200) begin
            n++;
            if (poke) begin
                rd_hi_i = n[0]; rd_lo_i = ~n[0]; start_i = n[1];
                a_i = 64'hDEAD_BEEF_0000_0001 + 64'(n); b_i = 64'd3; op_i = 2'b01;
            end
            @(negedge clk); #1;
            rd_hi_i = 1'b0; rd_lo_i = 1'b0; start_i = 1'b0;
        end
        exp_res(op, w, a, b, eh, el);
        check(n == exp_lat(op, w, b), ltag, "latency", 64'(n), 64'(exp_lat(op, w, b)));
        check(hi_o == eh, rtag, "final hi", hi_o, eh);
        check(lo_o == el, rtag, "final lo", lo_o, el);
    endtask

    initial begin
        #(20 * 150000);
        check(1'b0, "WATCHDOG", "timeout", 64'd0, 64'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int gap;
        repeat (4) @(negedge clk);
        // R1: reset state while reset is held
        check(hi_o == '0, "R1", "hi", hi_o, '0);
        check(lo_o == '0, "R1", "lo", lo_o, '0);
        check(busy_o == 1'b0, "R1", "busy", 64'(busy_o), '0);
        check(stall_o == 1'b0, "R1", "stall", 64'(stall_o), '0);
        #1 rst_n = 1'b1;
        checking = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b0 && hi_o == '0, "R1", "after release", hi_o, '0);

        // R2: full-width multiplies
        run_op(2'b00, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R2", "R6", 0);
        run_op(2'b01, 1'b1, 64'hFFFF_FFFF_FFFF_FFF9, 64'h0123_4567_89AB_CDEF, "R2", "R6", 0);
        run_op(2'b01, 1'b1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FF80, "R2", "R6", 0);
        // R6: each band at full width
        run_op(2'b00, 1'b1, 64'h1111_2222_3333_4444, 64'h0000_0000_0000_ABCD, "R6", "R6", 0);
        run_op(2'b00, 1'b1, 64'h1111_2222_3333_4444, 64'h0000_0000_89AB_CDEF, "R6", "R6", 0);
        run_op(2'b01, 1'b1, 64'h7, 64'hFFFF_FFFF_FFFF_FF7F, "R6", "R6", 0);
        // R3: 32-bit multiplies, junk in the upper operand halves
        run_op(2'b00, 1'b0, 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_0000_0005, "R3", "R6", 0);
        run_op(2'b01, 1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFD, "R3", "R6", 0);
        run_op(2'b01, 1'b0, 64'h0000_0000_0001_2345, 64'h0000_0000_0012_3456, "R3", "R6", 0);
        run_op(2'b00, 1'b0, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_1234_5678, "R3", "R6", 0);
        run_op(2'b01, 1'b0, 64'h0000_0000_0000_1234, 64'h0000_0000_FFFF_8000, "R6", "R6", 0);
        // R4 and R5: divides at both widths
        run_op(2'b10, 1'b0, 64'h0000_0000_FFFF_FFF0, 64'h0000_0000_0000_0007, "R4", "R5", 0);
        run_op(2'b11, 1'b0, 64'h0000_0000_FFFF_FF9C, 64'h0000_0000_0000_0007, "R4", "R5", 0);
        run_op(2'b11, 1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R4", "R5", 0);
        run_op(2'b11, 1'b1, 64'h0000_0000_0000_0064, 64'hFFFF_FFFF_FFFF_FFF9, "R4", "R5", 0);
        run_op(2'b10, 1'b1, 64'hFEDC_BA98_7654_3210, 64'h0000_0001_0000_0003, "R4", "R5", 0);
        run_op(2'b11, 1'b1, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0010, "R4", "R5", 0);
        // R7: zero divisors
        run_op(2'b11, 1'b0, 64'h0000_0000_8765_4321, 64'hFFFF_FFFF_0000_0000, "R7", "R5", 0);
        run_op(2'b10, 1'b1, 64'h0123_4567_89AB_CDEF, 64'h0, "R7", "R5", 0);
        run_op(2'b11, 1'b1, 64'hF000_0000_0000_0000, 64'h0, "R7", "R5", 0);
        // R8, R9 and R10: reads and starts poked into a running divide and multiply
        run_op(2'b11, 1'b1, 64'hFFFF_FFFF_FFFF_0001, 64'h0000_0000_0000_0013, "R10", "R5", 1);
        run_op(2'b00, 1'b1, 64'h0000_0000_DEAD_BEEF, 64'h0000_0000_0000_00FF, "R10", "R6", 1);

        // R11: idle reads do not stall
        @(negedge clk); #1;
        rd_hi_i = 1'b1; rd_lo_i = 1'b1;
        @(negedge clk);
        check(stall_o == 1'b0, "R11", "idle read stall", 64'(stall_o), '0);
        #1 rd_hi_i = 1'b0; rd_lo_i = 1'b0;

        // R11: start held high, so the second request follows after one idle cycle
        res_tag = "R11"; lat_tag = "R11";
        @(negedge clk); #1;
        op_i = 2'b01; wide_i = 1'b0; a_i = 64'd9; b_i = 64'd11; start_i = 1'b1;
        @(negedge clk); #1;
        a_i = 64'd12; b_i = 64'hFFFF_FFFF_FFFF_FFFE;
        while (busy_o) begin @(negedge clk); #1; end
        gap = 0;
        while (!busy_o && gap < 5) begin gap++; @(negedge clk); #1; end
        start_i = 1'b0;
        check(gap == 1, "R11", "idle gap", 64'(gap), 64'd1);
        while (busy_o) begin @(negedge clk); #1; end
        check(lo_o == 64'hFFFF_FFFF_FFFF_FFE8, "R11", "second result lo", lo_o,
              64'hFFFF_FFFF_FFFF_FFE8);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule